// File: doc/BRIEF.md
# Multiplexed Parallel I/O Port

This block controls a bank of up to 32 chip pins. Each pin works either as general-purpose I/O, owned by software through a small register bus, or as one of two dedicated peripheral functions, chosen per pin. Software programs five per-port registers: assignment, option select, direction, open-drain and data. Bit n of each register governs pin n.

On the pad side the block drives an output value and an output enable for each pin, and samples the incoming pad through a two-flop synchronizer. On the peripheral side, each pin offers two output interfaces, one per dedicated function, each with its own drive-request line, and one synchronized input. For an input pin whose option bit is set against the pad-routing value, that input is replaced by a fixed level chosen per pin at build time. The usual choice is low for request-type inputs and high for completion-type handshakes.

Top module: `pio_mux_port`

## Requirements
- R1: Reset (asynchronous, active-low `rst_n`) clears every register, so every register reads 0 and no pin drives (`pad_oe` all 0).
- R2: A write with `reg_we` high takes effect on the next rising clock edge. Register addresses are 0 assignment, 1 option, 2 direction, 3 open-drain and 4 data. Readback returns the stored bits in positions below NPINS and 0 above them. Addresses 5 to 7 read 0.
- R3: A general-purpose pin (assignment bit 0) with direction bit 1 and open-drain bit 0 drives its data register bit with `pad_oe` high.
- R4: Reading address 4 returns the data register bit for pins with direction 1. For pins with direction 0 it returns the pad value through two flops: after the first clock edge the old value is still read, and after the second the new value appears.
- R5: A pin with open-drain bit 1 never drives high. When its outgoing value is 1 the output enable is 0. When the value is 0 it drives 0 with the enable set.
- R6: A dedicated pin (assignment bit 1) takes its output value from `fn1_dout` when its option bit is 0 and from `fn2_dout` when it is 1. With direction 1 it drives.
- R7: A dedicated pin with direction 0 drives only when the drive request of the selected function (`fn1_oe` for option 0, `fn2_oe` for option 1) is high.
- R8: `periph_din[n]` carries the synchronized pad value when assignment bit n is 1 and either direction bit n is 1 or option bit n equals PAD_OPT[n] (default PAD_OPT low byte 0x0F).
- R9: `periph_din[n]` carries DEF_LVL[n] (default low byte 0xA5) when assignment bit n is 0, or when direction bit n is 0 and option bit n differs from PAD_OPT[n].
- R10: A general-purpose pin with direction 0 never drives its pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| pad_in | input | NPINS | Raw pad input values |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| fn1_dout | input | NPINS | Dedicated function 1 output values |
| fn1_oe | input | NPINS | Dedicated function 1 drive requests |
| fn2_dout | input | NPINS | Dedicated function 2 output values |
| fn2_oe | input | NPINS | Dedicated function 2 drive requests |
| periph_din | output | NPINS | Synchronized pad, or per-pin default, to peripherals |

## Verification
The bench uses opposite bit patterns in the two halves of the port, so that a swapped function select shows up as a nibble exchange on `pad_out` and `pad_oe`. It reads the data register one edge and two edges after a pad change. A design with one flop too few or too many in the synchronizer returns the new value at the wrong read. For the default-injection rule the bench uses option settings that match, mismatch and partly match the pad-routing vector. A design that ignores the direction term or inverts the comparison hands the pad to the peripheral when it should not. Open-drain is checked on a mix of ones and zeros, so a design that drives high or releases a low is caught.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int MAX_PINS = 32;
   localparam int ADDR_W   = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_ASSIGN = 3'd0,
      REG_OPTION = 3'd1,
      REG_DIR    = 3'd2,
      REG_ODRN   = 3'd3,
      REG_DATA   = 3'd4
   } pio_reg_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage1;
   logic [W-1:0] stage2;
   logic [1:0]   warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= '0;
         stage2 <= '0;
      end else begin
         stage1 <= d;
         stage2 <= stage1;
      end
   end

   assign q = stage2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          warm <= 2'd0;
      else if (warm != 2'd2) warm <= warm + 2'd1;
   end

   a_r4_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/pio_regs.sv
module pio_regs
   import pio_pkg::*;
#(
   parameter int NPINS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [MAX_PINS-1:0]  wdata,
   output logic [MAX_PINS-1:0]  rdata,
   input  logic [NPINS-1:0]     pad_sync,
   output logic [NPINS-1:0]     assign_q,
   output logic [NPINS-1:0]     option_q,
   output logic [NPINS-1:0]     dir_q,
   output logic [NPINS-1:0]     odrn_q,
   output logic [NPINS-1:0]     data_q
);
   logic [NPINS-1:0] wbits;
   logic [NPINS-1:0] rbits;
   logic             rhit;
   logic             unused_wdata;

   assign wbits        = wdata[NPINS-1:0];
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         assign_q <= '0;
         option_q <= '0;
         dir_q    <= '0;
         odrn_q   <= '0;
         data_q   <= '0;
      end else if (we) begin
         case (addr)
            REG_ASSIGN: assign_q <= wbits;
            REG_OPTION: option_q <= wbits;
            REG_DIR:    dir_q    <= wbits;
            REG_ODRN:   odrn_q   <= wbits;
            REG_DATA:   data_q   <= wbits;
            default: ;
         endcase
      end
   end

   always_comb begin
      rhit  = 1'b1;
      rbits = '0;
      case (addr)
         REG_ASSIGN: rbits = assign_q;
         REG_OPTION: rbits = option_q;
         REG_DIR:    rbits = dir_q;
         REG_ODRN:   rbits = odrn_q;
         REG_DATA:   rbits = (dir_q & data_q) | (~dir_q & pad_sync);
         default:    rhit  = 1'b0;
      endcase
      rdata = '0;
      if (rhit) rdata[NPINS-1:0] = rbits;
   end

   a_r2_dir_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == REG_DIR) |=> (dir_q == $past(wdata[NPINS-1:0])));
   a_r2_assign_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && addr == REG_ASSIGN) |=> $stable(assign_q));
endmodule

// File: rtl/pio_pin_mux.sv
module pio_pin_mux #(
   parameter int               NPINS   = 8,
   parameter logic [NPINS-1:0] DEF_LVL = '0,
   parameter logic [NPINS-1:0] PAD_OPT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] assign_q,
   input  logic [NPINS-1:0] option_q,
   input  logic [NPINS-1:0] dir_q,
   input  logic [NPINS-1:0] odrn_q,
   input  logic [NPINS-1:0] data_q,
   input  logic [NPINS-1:0] pad_sync,
   input  logic [NPINS-1:0] fn1_dout,
   input  logic [NPINS-1:0] fn1_oe,
   input  logic [NPINS-1:0] fn2_dout,
   input  logic [NPINS-1:0] fn2_oe,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] periph_din
);
   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic val;
      logic want_drive;
      logic route_pad;

      always_comb begin
         if (assign_q[i]) begin
            val        = option_q[i] ? fn2_dout[i] : fn1_dout[i];
            want_drive = dir_q[i] | (option_q[i] ? fn2_oe[i] : fn1_oe[i]);
         end else begin
            val        = data_q[i];
            want_drive = dir_q[i];
         end
      end

      assign route_pad = assign_q[i] & (dir_q[i] | (option_q[i] == PAD_OPT[i]));

      assign pad_out[i]    = odrn_q[i] ? 1'b0 : val;
      assign pad_oe[i]     = want_drive & ~(odrn_q[i] & val);
      assign periph_din[i] = route_pad ? pad_sync[i] : DEF_LVL[i];

      a_r5_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
         (odrn_q[i] && pad_oe[i]) |-> !pad_out[i]);
      a_r10_gpio_in_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (!assign_q[i] && !dir_q[i]) |-> !pad_oe[i]);
      a_r3_gpio_out_drive: assert property (@(posedge clk) disable iff (!rst_n)
         (!assign_q[i] && dir_q[i] && !odrn_q[i]) |-> (pad_oe[i] && pad_out[i] == data_q[i]));
      a_r9_default_inject: assert property (@(posedge clk) disable iff (!rst_n)
         (!assign_q[i] || (!dir_q[i] && option_q[i] != PAD_OPT[i])) |-> (periph_din[i] == DEF_LVL[i]));
   end
endmodule

// File: rtl/pio_mux_port.sv
module pio_mux_port
   import pio_pkg::*;
#(
   parameter int          NPINS   = 8,
   parameter logic [31:0] DEF_LVL = 32'h0000_00A5,
   parameter logic [31:0] PAD_OPT = 32'h0000_000F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe,
   input  logic [NPINS-1:0] fn1_dout,
   input  logic [NPINS-1:0] fn1_oe,
   input  logic [NPINS-1:0] fn2_dout,
   input  logic [NPINS-1:0] fn2_oe,
   output logic [NPINS-1:0] periph_din
);
   localparam logic [NPINS-1:0] DEF_V = DEF_LVL[NPINS-1:0];
   localparam logic [NPINS-1:0] OPT_V = PAD_OPT[NPINS-1:0];

   if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_width
      $error("pio_mux_port: NPINS out of range");
   end

   logic [NPINS-1:0] pad_sync;
   logic [NPINS-1:0] assign_q, option_q, dir_q, odrn_q, data_q;

   pio_sync #(.W(NPINS)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
   );

   pio_regs #(.NPINS(NPINS)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .pad_sync(pad_sync),
      .assign_q(assign_q), .option_q(option_q), .dir_q(dir_q),
      .odrn_q(odrn_q), .data_q(data_q)
   );

   pio_pin_mux #(.NPINS(NPINS), .DEF_LVL(DEF_V), .PAD_OPT(OPT_V)) u_mux (
      .clk(clk), .rst_n(rst_n),
      .assign_q(assign_q), .option_q(option_q), .dir_q(dir_q),
      .odrn_q(odrn_q), .data_q(data_q), .pad_sync(pad_sync),
      .fn1_dout(fn1_dout), .fn1_oe(fn1_oe), .fn2_dout(fn2_dout), .fn2_oe(fn2_oe),
      .pad_out(pad_out), .pad_oe(pad_oe), .periph_din(periph_din)
   );

   always_comb begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (pad_oe == '0);
      end
   end
endmodule

// File: tb/pio_mux_port_tb.sv
module pio_mux_port_tb;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [2:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic [N-1:0] pad_in = '0, pad_out, pad_oe, periph_din;
   logic [N-1:0] fn1_dout = '0, fn1_oe = '0, fn2_dout = '0, fn2_oe = '0;

   typedef struct {
      string       tag;
      int          sel;
      logic [31:0] exp;
   } item_t;

   item_t q[$];
   int    n_run  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;

   always #10 clk = ~clk;

   pio_mux_port u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .fn1_dout(fn1_dout), .fn1_oe(fn1_oe),
      .fn2_dout(fn2_dout), .fn2_oe(fn2_oe), .periph_din(periph_din)
   );

   // monitor: sel 0 rdata, 1 pad_oe, 2 pad_out, 3 periph_din
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t       it;
         logic [31:0] act;
         it = q.pop_front();
         case (it.sel)
            0:       act = reg_rdata;
            1:       act = {24'd0, pad_oe};
            2:       act = {24'd0, pad_out};
            default: act = {24'd0, periph_din};
         endcase
         n_run++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic expect_v(input int sel, input logic [31:0] exp, input string tag);
      item_t it;
      it.tag = tag; it.sel = sel; it.exp = exp;
      q.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      reg_addr = a;
      expect_v(0, exp, tag);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); #1;
      reg_we = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: stimulus incomplete, actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk); #1;
      expect_v(1, 32'h0, "R1 no drive in reset");
      rst_n = 1'b1;
      for (int a = 0; a < 5; a++) rd(a[2:0], 32'h0, "R1 reset register value");
      expect_v(1, 32'h0, "R10 gpio inputs quiet after reset");

      // R2
      wr(3'd0, 32'hFFFF_FF3C);
      rd(3'd0, 32'h3C, "R2 assign readback masked");
      rd(3'd7, 32'h0, "R2 unused address reads 0");
      wr(3'd0, 32'h0);
      rd(3'd0, 32'h0, "R2 assign cleared");

      // R3 / R4 output readback
      wr(3'd2, 32'hFF);
      wr(3'd4, 32'h5A);
      expect_v(1, 32'hFF, "R3 gpio output enable");
      expect_v(2, 32'h5A, "R3 gpio output value");
      rd(3'd4, 32'h5A, "R4 data readback for outputs");

      // R5
      wr(3'd3, 32'h0F);
      expect_v(1, 32'hF5, "R5 open-drain releases ones");
      expect_v(2, 32'h50, "R5 open-drain drives zeros low");
      wr(3'd3, 32'h0);

      // R4 synchronizer depth, R10
      wr(3'd2, 32'h0);
      reg_addr = 3'd4;
      pad_in = 8'hC3;
      expect_v(0, 32'h00, "R4 one edge: old pad value");
      expect_v(0, 32'hC3, "R4 two edges: new pad value");
      expect_v(1, 32'h00, "R10 gpio input does not drive");

      // R6 dedicated outputs
      fn1_dout = 8'h33; fn2_dout = 8'hCC;
      fn1_oe = 8'h0F; fn2_oe = 8'hF0;
      wr(3'd0, 32'hFF);
      wr(3'd2, 32'hFF);
      wr(3'd1, 32'hF0);
      expect_v(2, 32'hC3, "R6 per-pin function select");
      expect_v(1, 32'hFF, "R6 dedicated output drives");
      expect_v(3, 32'hC3, "R8 dedicated output pin sees pad");

      // R7 bidirectional drive requests
      wr(3'd2, 32'h0);
      expect_v(1, 32'hFF, "R7 selected drive request (opt F0)");
      wr(3'd1, 32'h0F);
      expect_v(1, 32'h00, "R7 selected drive request (opt 0F)");
      expect_v(2, 32'h3C, "R6 swapped function select");

      // R8 / R9 default injection
      expect_v(3, 32'hC3, "R8 option matches routing: pad");
      wr(3'd1, 32'hF0);
      expect_v(3, 32'hA5, "R9 option mismatch: default");
      wr(3'd1, 32'h00);
      expect_v(3, 32'hC5, "R9 R8 mixed match");
      wr(3'd0, 32'h0);
      expect_v(3, 32'hA5, "R9 gpio mode: default");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule